// File: doc/BRIEF.md
# Descending Stack Context Save Unit

This block saves CPU state to a small stack in internal RAM and restores it. It handles four cases: a subroutine call, interrupt entry, a subroutine return and a return from interrupt. It owns the stack pointer. The pointer lives in a 31-byte window at the top of the 112-byte user RAM, and that window is shared with ordinary data. Each saved or restored byte costs one memory cycle on a plain byte-wide bus.

A one-cycle start strobe selects the sequence. On a call the unit writes only the 12-bit program counter, as two bytes. On interrupt entry it writes the program counter, the index register, the accumulator and the condition codes. The two return sequences read the same bytes back in mirror order and present the restored values on the outputs. A one-cycle done pulse marks the end of each sequence.

The memory side has no back-pressure. The RAM must accept a write, or return read data combinationally, in every cycle where an access is issued. Start strobes are plain control inputs, and strobes that arrive while the unit is busy are dropped.

Top module: `ctx_stack_seq`

## Requirements
- R1: After reset the stack pointer is 0x07F, busy and done are 0, no memory access is issued, and pc_out, a_out, x_out and cc_out are 0.
- R2: A push writes to the address held in the stack pointer and then decrements the pointer. A pull first increments the pointer and then reads from the new value.
- R3: The stack pointer stays inside 0x061..0x07F. Decrementing from 0x061 gives 0x07F, and incrementing from 0x07F gives 0x061.
- R4: A call writes two bytes. The first is PCL (pc bits 7:0). The second is PCH: pc bits 11:8 in data bits 3:0, with bits 7:4 set to zero.
- R5: Interrupt entry writes five bytes in this order: PCL, PCH, X, A, CC.
- R6: A return reads PCH and then PCL into pc_out. The upper four bits of the PCH byte are ignored.
- R7: A return from interrupt reads CC, A, X, PCH and PCL in that order, and loads cc_out, a_out, x_out and pc_out.
- R8: A strobe is sampled at a clock edge. From the next cycle the unit issues exactly one access per cycle, in consecutive cycles, and busy is 1 in every access cycle. mem_wr and mem_rd are never both 1.
- R9: done is 1 for exactly one cycle: the cycle after the final access. The restored outputs are valid in that cycle.
- R10: Strobes that arrive in a cycle where busy is 1 are ignored. A strobe in the done cycle is accepted.
- R11: When more than one strobe is high in the same cycle, the priority is interrupt, then call, then return from interrupt, then return.
- R12: pc_in, a_in, x_in and cc_in are captured at the edge that accepts the strobe. Changes to them during the sequence do not change the bytes written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| call_go | input | 1 | Start a subroutine-call push |
| irq_go | input | 1 | Start an interrupt-entry push |
| ret_go | input | 1 | Start a subroutine-return pull |
| rti_go | input | 1 | Start a return-from-interrupt pull |
| pc_in | input | 12 | Program counter to save |
| a_in | input | 8 | Accumulator to save |
| x_in | input | 8 | Index register to save |
| cc_in | input | 8 | Condition codes to save |
| mem_addr | output | 12 | RAM byte address of the current access |
| mem_wr | output | 1 | Write access this cycle |
| mem_rd | output | 1 | Read access this cycle |
| mem_wdata | output | 8 | Write data |
| mem_rdata | input | 8 | Read data, valid in the same cycle as mem_rd |
| pc_out | output | 12 | Restored program counter |
| a_out | output | 8 | Restored accumulator |
| x_out | output | 8 | Restored index register |
| cc_out | output | 8 | Restored condition codes |
| sp | output | 12 | Current stack pointer |
| busy | output | 1 | A sequence is issuing accesses |
| done | output | 1 | One-cycle end-of-sequence pulse |

## Verification
On every cycle, the assertions check that:
- the stack pointer stays inside the window and moves one step per access in the correct direction;
- reads and writes never overlap;
- the PCH byte carries zero upper bits;
- the saved snapshot does not change while busy;
- done lasts a single cycle and follows the final access.

Only the bench scenarios can show the complete byte orders of the four sequences, the wrap of the pointer across many nested calls, the outcome when strobes arrive together, and the restored values. The bench compares its queue-driven model against the design on every clock.

// File: rtl/ctx_stack_pkg.sv
package ctx_stack_pkg;

  typedef enum logic [2:0] {
    OP_NONE = 3'd0,
    OP_CALL = 3'd1,
    OP_IRQ  = 3'd2,
    OP_RET  = 3'd3,
    OP_RTI  = 3'd4
  } op_e;

  typedef enum logic [2:0] {
    SL_PCL = 3'd0,
    SL_PCH = 3'd1,
    SL_X   = 3'd2,
    SL_A   = 3'd3,
    SL_CC  = 3'd4
  } slot_e;

  localparam int unsigned IDX_W = 3;

  // number of byte accesses in a sequence
  function automatic logic [IDX_W-1:0] seq_len(input op_e op);
    case (op)
      OP_CALL, OP_RET: seq_len = 3'd2;
      OP_IRQ, OP_RTI:  seq_len = 3'd5;
      default:         seq_len = 3'd1;
    endcase
  endfunction

  // which register a given step of a sequence moves
  function automatic slot_e seq_slot(input op_e op, input logic [IDX_W-1:0] idx);
    seq_slot = SL_PCL;
    case (op)
      OP_CALL, OP_IRQ: begin
        case (idx)
          3'd0:    seq_slot = SL_PCL;
          3'd1:    seq_slot = SL_PCH;
          3'd2:    seq_slot = SL_X;
          3'd3:    seq_slot = SL_A;
          default: seq_slot = SL_CC;
        endcase
      end
      OP_RET: seq_slot = (idx == 3'd0) ? SL_PCH : SL_PCL;
      OP_RTI: begin
        case (idx)
          3'd0:    seq_slot = SL_CC;
          3'd1:    seq_slot = SL_A;
          3'd2:    seq_slot = SL_X;
          3'd3:    seq_slot = SL_PCH;
          default: seq_slot = SL_PCL;
        endcase
      end
      default: seq_slot = SL_PCL;
    endcase
  endfunction

endpackage

// File: rtl/ctx_seq_ctrl.sv
module ctx_seq_ctrl
  import ctx_stack_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             call_go,
  input  logic             irq_go,
  input  logic             ret_go,
  input  logic             rti_go,
  output logic             start,
  output logic             busy,
  output logic             done,
  output logic             push,
  output logic             pull,
  output slot_e            slot
);

  op_e              op_q;
  op_e              op_sel;
  logic [IDX_W-1:0] idx_q;
  logic             busy_q;
  logic             done_q;
  logic             last;

  // fixed priority among simultaneous strobes
  always_comb begin
    if (irq_go)       op_sel = OP_IRQ;
    else if (call_go) op_sel = OP_CALL;
    else if (rti_go)  op_sel = OP_RTI;
    else if (ret_go)  op_sel = OP_RET;
    else              op_sel = OP_NONE;
  end

  assign start = !busy_q && (op_sel != OP_NONE);
  assign last  = (idx_q == IDX_W'(seq_len(op_q) - 3'd1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      op_q   <= OP_NONE;
      idx_q  <= '0;
      busy_q <= 1'b0;
      done_q <= 1'b0;
    end else begin
      done_q <= busy_q && last;
      if (start) begin
        op_q   <= op_sel;
        idx_q  <= '0;
        busy_q <= 1'b1;
      end else if (busy_q) begin
        idx_q <= idx_q + 1'b1;
        if (last) begin
          busy_q <= 1'b0;
          op_q   <= OP_NONE;
        end
      end
    end
  end

  assign busy = busy_q;
  assign done = done_q;
  assign push = busy_q && ((op_q == OP_CALL) || (op_q == OP_IRQ));
  assign pull = busy_q && ((op_q == OP_RET) || (op_q == OP_RTI));
  assign slot = seq_slot(op_q, idx_q);

  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |=> !done_q);  // R9
  AST_DONE_AFTER_LAST: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && last) |=> (done_q && !busy_q));  // R9
  AST_OP_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && !last) |=> (busy_q && $stable(op_q)));  // R10

endmodule

// File: rtl/ctx_sp_ptr.sv
module ctx_sp_ptr #(
  parameter int unsigned AW     = 12,
  parameter logic [AW-1:0] SP_LO = 12'h061,
  parameter logic [AW-1:0] SP_HI = 12'h07F
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push,
  input  logic          pull,
  output logic [AW-1:0] sp,
  output logic [AW-1:0] addr
);

  logic [AW-1:0] sp_q;
  logic [AW-1:0] sp_dn;
  logic [AW-1:0] sp_up;

  assign sp_dn = (sp_q == SP_LO) ? SP_HI : sp_q - 1'b1;
  assign sp_up = (sp_q == SP_HI) ? SP_LO : sp_q + 1'b1;

  always_ff @(posedge clk) begin
    if (!rst_n)    sp_q <= SP_HI;
    else if (push) sp_q <= sp_dn;
    else if (pull) sp_q <= sp_up;
  end

  assign sp   = sp_q;
  assign addr = pull ? sp_up : sp_q;

  AST_SP_IN_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
    (sp_q >= SP_LO) && (sp_q <= SP_HI));  // R3
  AST_PUSH_STEPS_DOWN: assert property (@(posedge clk) disable iff (!rst_n)
    push |=> ((sp_q == $past(addr) - 1'b1) || ($past(addr) == SP_LO && sp_q == SP_HI)));  // R2
  AST_PULL_LANDS_ON_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
    pull |=> (sp_q == $past(addr)));  // R2
  AST_ONE_DIRECTION: assert property (@(posedge clk) disable iff (!rst_n)
    !(push && pull));  // R8

endmodule

// File: rtl/ctx_byte_route.sv
module ctx_byte_route
  import ctx_stack_pkg::*;
#(
  parameter int unsigned AW = 12,
  parameter int unsigned DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic          busy,
  input  logic          push,
  input  logic          pull,
  input  slot_e         slot,
  input  logic [AW-1:0] pc_in,
  input  logic [DW-1:0] a_in,
  input  logic [DW-1:0] x_in,
  input  logic [DW-1:0] cc_in,
  input  logic [DW-1:0] rdata,
  output logic [DW-1:0] wdata,
  output logic [AW-1:0] pc_out,
  output logic [DW-1:0] a_out,
  output logic [DW-1:0] x_out,
  output logic [DW-1:0] cc_out
);

  localparam int unsigned HIW = AW - DW;

  logic [AW-1:0] snap_pc;
  logic [DW-1:0] snap_a, snap_x, snap_cc;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      snap_pc <= '0;
      snap_a  <= '0;
      snap_x  <= '0;
      snap_cc <= '0;
    end else if (start) begin
      snap_pc <= pc_in;
      snap_a  <= a_in;
      snap_x  <= x_in;
      snap_cc <= cc_in;
    end
  end

  always_comb begin
    case (slot)
      SL_PCL:  wdata = snap_pc[DW-1:0];
      SL_PCH:  wdata = {{(DW-HIW){1'b0}}, snap_pc[AW-1:DW]};
      SL_X:    wdata = snap_x;
      SL_A:    wdata = snap_a;
      default: wdata = snap_cc;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pc_out <= '0;
      a_out  <= '0;
      x_out  <= '0;
      cc_out <= '0;
    end else if (pull) begin
      case (slot)
        SL_PCL:  pc_out[DW-1:0]  <= rdata;
        SL_PCH:  pc_out[AW-1:DW] <= rdata[HIW-1:0];
        SL_X:    x_out           <= rdata;
        SL_A:    a_out           <= rdata;
        default: cc_out          <= rdata;
      endcase
    end
  end

  AST_PCH_ZERO_TOP: assert property (@(posedge clk) disable iff (!rst_n)
    (push && slot == SL_PCH) |-> (wdata[DW-1:HIW] == '0));  // R4
  AST_SNAPSHOT_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> ($stable(snap_pc) && $stable(snap_a) && $stable(snap_x) && $stable(snap_cc)));  // R12
  AST_PCL_KEEPS_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    (pull && slot == SL_PCL) |=> (pc_out[AW-1:DW] == $past(pc_out[AW-1:DW])));  // R6

endmodule

// File: rtl/ctx_stack_seq.sv
module ctx_stack_seq
  import ctx_stack_pkg::*;
#(
  parameter int unsigned AW     = 12,
  parameter int unsigned DW     = 8,
  parameter logic [AW-1:0] SP_LO = 12'h061,
  parameter logic [AW-1:0] SP_HI = 12'h07F
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          call_go,
  input  logic          irq_go,
  input  logic          ret_go,
  input  logic          rti_go,
  input  logic [AW-1:0] pc_in,
  input  logic [DW-1:0] a_in,
  input  logic [DW-1:0] x_in,
  input  logic [DW-1:0] cc_in,
  output logic [AW-1:0] mem_addr,
  output logic          mem_wr,
  output logic          mem_rd,
  output logic [DW-1:0] mem_wdata,
  input  logic [DW-1:0] mem_rdata,
  output logic [AW-1:0] pc_out,
  output logic [DW-1:0] a_out,
  output logic [DW-1:0] x_out,
  output logic [DW-1:0] cc_out,
  output logic [AW-1:0] sp,
  output logic          busy,
  output logic          done
);

  logic  start_w, push_w, pull_w;
  slot_e slot_w;

  ctx_seq_ctrl u_ctrl (
    .clk     (clk),
    .rst_n   (rst_n),
    .call_go (call_go),
    .irq_go  (irq_go),
    .ret_go  (ret_go),
    .rti_go  (rti_go),
    .start   (start_w),
    .busy    (busy),
    .done    (done),
    .push    (push_w),
    .pull    (pull_w),
    .slot    (slot_w)
  );

  ctx_sp_ptr #(.AW(AW), .SP_LO(SP_LO), .SP_HI(SP_HI)) u_sp (
    .clk   (clk),
    .rst_n (rst_n),
    .push  (push_w),
    .pull  (pull_w),
    .sp    (sp),
    .addr  (mem_addr)
  );

  ctx_byte_route #(.AW(AW), .DW(DW)) u_route (
    .clk    (clk),
    .rst_n  (rst_n),
    .start  (start_w),
    .busy   (busy),
    .push   (push_w),
    .pull   (pull_w),
    .slot   (slot_w),
    .pc_in  (pc_in),
    .a_in   (a_in),
    .x_in   (x_in),
    .cc_in  (cc_in),
    .rdata  (mem_rdata),
    .wdata  (mem_wdata),
    .pc_out (pc_out),
    .a_out  (a_out),
    .x_out  (x_out),
    .cc_out (cc_out)
  );

  assign mem_wr = push_w;
  assign mem_rd = pull_w;

  AST_ACCESS_ONLY_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_wr || mem_rd) |-> busy);  // R8
  AST_NO_ACCESS_ON_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !(mem_wr || mem_rd));  // R9

endmodule

// File: tb/tb_ctx_stack_seq.sv
`timescale 1ns/1ps
module tb_ctx_stack_seq;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        call_go = 0, irq_go = 0, ret_go = 0, rti_go = 0;
  logic [11:0] pc_in = '0;
  logic [7:0]  a_in = '0, x_in = '0, cc_in = '0;
  logic [11:0] mem_addr;
  logic        mem_wr, mem_rd;
  logic [7:0]  mem_wdata, mem_rdata;
  logic [11:0] pc_out, sp;
  logic [7:0]  a_out, x_out, cc_out;
  logic        busy, done;

  always #2.5 clk = ~clk;

  ctx_stack_seq dut (
    .clk(clk), .rst_n(rst_n),
    .call_go(call_go), .irq_go(irq_go), .ret_go(ret_go), .rti_go(rti_go),
    .pc_in(pc_in), .a_in(a_in), .x_in(x_in), .cc_in(cc_in),
    .mem_addr(mem_addr), .mem_wr(mem_wr), .mem_rd(mem_rd),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
    .pc_out(pc_out), .a_out(a_out), .x_out(x_out), .cc_out(cc_out),
    .sp(sp), .busy(busy), .done(done)
  );

  // RAM model: write on the edge, combinational read
  logic [7:0] ram [0:127];
  always @(posedge clk) if (mem_wr) ram[mem_addr[6:0]] <= mem_wdata;
  assign mem_rdata = ram[mem_addr[6:0]];

  // reference model state
  typedef struct { bit wr; int slot; } acc_t;  // slot 0 PCL 1 PCH 2 X 3 A 4 CC
  acc_t q[$];
  int   m_sp, m_pc, m_a, m_x, m_cc, e_pc, e_a, e_x, e_cc;
  bit   done_pend;
  int   exp_ram [0:127];
  int   n_chk = 0, n_fail = 0;

  function automatic int dn(int v); return (v == 'h61) ? 'h7F : v - 1; endfunction
  function automatic int up(int v); return (v == 'h7F) ? 'h61 : v + 1; endfunction

  task automatic check(bit ok, string tag, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=0x%0h expected=0x%0h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic int slot_byte(int s);
    case (s)
      0: return m_pc & 'hFF;
      1: return (m_pc >> 8) & 'hF;
      2: return m_x;
      3: return m_a;
      default: return m_cc;
    endcase
  endfunction

  task automatic launch(bit c, bit i, bit r, bit t);
    int ord[$];
    bit wr;
    // R11 priority: interrupt, call, rti, ret
    if (i)      begin wr = 1; ord = '{0, 1, 2, 3, 4}; end
    else if (c) begin wr = 1; ord = '{0, 1}; end
    else if (t) begin wr = 0; ord = '{4, 3, 2, 1, 0}; end
    else        begin wr = 0; ord = '{1, 0}; end
    // R12: snapshot taken now
    m_pc = pc_in; m_a = a_in; m_x = x_in; m_cc = cc_in;
    foreach (ord[k]) q.push_back('{wr: wr, slot: ord[k]});
  endtask

  task automatic tick(bit c, bit i, bit r, bit t, int pc, int a, int x, int cc);
    bit busy_now;
    @(negedge clk);
    busy_now = (q.size() > 0);
    if (busy_now) begin
      acc_t rec;
      int   ad;
      rec = q.pop_front();
      ad  = rec.wr ? m_sp : up(m_sp);
      check(busy == 1'b1 && done == 1'b0, "R8 busy/done in access cycle", {busy, done}, 2);
      check(mem_wr == rec.wr && mem_rd == !rec.wr, "R8 access kind", {mem_wr, mem_rd}, {rec.wr, !rec.wr});
      check(sp == m_sp, "R3 stack pointer", sp, m_sp);
      check(mem_addr == ad, "R2 access address", mem_addr, ad);
      if (rec.wr) begin
        int d = slot_byte(rec.slot);
        check(mem_wdata == d, rec.slot == 1 ? "R4 PCH write data" : "R5 write data", mem_wdata, d);
        exp_ram[ad & 'h7F] = d;
        m_sp = dn(m_sp);
      end else begin
        int d = exp_ram[ad & 'h7F];
        case (rec.slot)
          0: e_pc = (e_pc & 'hF00) | d;
          1: e_pc = (e_pc & 'h0FF) | ((d & 'hF) << 8);
          2: e_x = d;
          3: e_a = d;
          default: e_cc = d;
        endcase
        m_sp = up(m_sp);
      end
      if (q.size() == 0) done_pend = 1;
    end else begin
      check(busy == 1'b0 && !mem_wr && !mem_rd, "R8 idle no access", {busy, mem_wr, mem_rd}, 0);
      check(done == done_pend, "R9 done pulse", done, done_pend);
      check(sp == m_sp, "R3 stack pointer idle", sp, m_sp);
      if (done_pend) begin
        check(pc_out == e_pc, "R6 restored pc", pc_out, e_pc);
        check({a_out, x_out, cc_out} == {e_a[7:0], e_x[7:0], e_cc[7:0]}, "R7 restored regs",
              {a_out, x_out, cc_out}, {e_a[7:0], e_x[7:0], e_cc[7:0]});
      end
      done_pend = 0;
    end
    call_go = c; irq_go = i; ret_go = r; rti_go = t;
    pc_in = 12'(pc); a_in = 8'(a); x_in = 8'(x); cc_in = 8'(cc);
    // R10: only accepted when not busy in this cycle
    if (!busy_now && (c || i || r || t)) launch(c, i, r, t);
  endtask

  task automatic idle(int n);
    for (int k = 0; k < n; k++) tick(0, 0, 0, 0, 0, 0, 0, 0);
  endtask

  task automatic summary();
    $display("  %0d/%0d checks passed", n_chk - n_fail, n_chk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired");
    summary();
    $finish;
  end

  initial begin
    for (int k = 0; k < 128; k++) begin ram[k] = 8'h00; exp_ram[k] = 0; end
    m_sp = 'h7F; e_pc = 0; e_a = 0; e_x = 0; e_cc = 0; done_pend = 0;
    repeat (3) @(negedge clk);
    // R1 reset state
    check(sp == 12'h07F, "R1 reset sp", sp, 'h7F);
    check(!busy && !done && !mem_wr && !mem_rd, "R1 reset control", {busy, done, mem_wr, mem_rd}, 0);
    check(pc_out == 0 && a_out == 0 && x_out == 0 && cc_out == 0, "R1 reset outputs", pc_out, 0);
    rst_n = 1'b1;
    idle(2);

    // R4 call then R6 return (upper PCH bits ignored on pull)
    tick(1, 0, 0, 0, 'hABC, 0, 0, 0);
    idle(4);
    tick(0, 0, 1, 0, 0, 0, 0, 0);
    idle(4);

    // R5 interrupt; R10 strobes while busy ignored; R12 inputs altered mid-sequence
    tick(0, 1, 0, 0, 'h5A3, 'h11, 'h22, 'hC5);
    tick(1, 0, 1, 1, 'hFFF, 'hEE, 'hDD, 'hBB);
    tick(0, 1, 0, 0, 'h123, 'h44, 'h55, 'h66);
    idle(6);
    // R7 return from interrupt
    tick(0, 0, 0, 1, 0, 0, 0, 0);
    idle(7);

    // R11 all strobes together: interrupt wins, then ret+rti: rti wins
    tick(1, 1, 1, 1, 'h7E1, 'h9A, 'hBC, 'h0F);
    idle(6);
    tick(0, 0, 1, 1, 0, 0, 0, 0);
    idle(6);
    // call beats rti and ret
    tick(1, 0, 1, 1, 'h3C4, 0, 0, 0);
    idle(3);
    // R10 strobe in the done cycle is accepted (back-to-back)
    tick(0, 0, 1, 0, 0, 0, 0, 0);
    tick(0, 0, 0, 0, 0, 0, 0, 0);
    tick(0, 0, 0, 0, 0, 0, 0, 0);
    tick(1, 0, 0, 0, 'h9F0, 0, 0, 0);
    idle(4);

    // R3 nested calls overflow the 31-byte window and wrap, then unwind
    for (int n = 0; n < 20; n++) begin
      tick(1, 0, 0, 0, 'h100 + n * 'h71, 0, 0, 0);
      idle(3);
    end
    for (int n = 0; n < 22; n++) begin
      tick(0, 0, 1, 0, 0, 0, 0, 0);
      idle(3);
    end
    for (int n = 0; n < 8; n++) begin
      tick(0, 1, 0, 0, 'h200 + n, n, n + 1, n + 2);
      idle(6);
    end
    for (int n = 0; n < 8; n++) begin
      tick(0, 0, 0, 1, 0, 0, 0, 0);
      idle(6);
    end
    idle(3);
    summary();
    $finish;
  end

endmodule